// File: doc/BRIEF.md
# Receive Byte Queue with Hysteretic RTS Flow Control

This block sits between a serial receiver and a host that reads received bytes. Bytes from the receiver are written into a 32-entry circular store. The host sees the oldest stored byte together with a data-available flag, and it removes that byte with a one-cycle pop strobe. The queue keeps a fill level and two wrapping pointers. When the queue is full, incoming bytes are thrown away without disturbing anything already stored.

An active-low request-to-send output controls the remote sender using two watermarks. The line goes high (stop) on the cycle after a lone write brings the fill level up to half the depth. It goes low again (resume) after a lone read brings the level down to a quarter of the depth. Between those two levels the line keeps its state. A synchronous reset or a flush strobe empties the queue and drives the line low. Some channels have no flow-control wire. For those, a build parameter removes the watermark logic and holds the output permanently low.

Top module: `rxq_flowctl`

## Requirements
- R1: After a reset cycle, rd_valid is 0 and rts_n is 0.
- R2: Bytes leave in the order they were accepted. While rd_valid is 1, rd_data shows the oldest accepted byte. A pop with rd_pop=1 removes that byte at the next clock edge.
- R3: A write while the queue holds 32 bytes is dropped. The fill level stays at 32 and the stored bytes are unchanged. If a pop arrives in the same cycle, the pop is still performed.
- R4: A cycle with an accepted write, no accepted pop, and a level of 15 sets rts_n to 1 on the next cycle.
- R5: A cycle with an accepted pop, no accepted write, and a level of 9 sets rts_n to 0 on the next cycle.
- R6: While the level is between the two watermarks, rts_n keeps its previous value. A cycle with both an accepted write and an accepted pop leaves the level and rts_n unchanged.
- R7: The write and read positions wrap from entry 31 back to entry 0, so byte order is kept across any number of passes through the store.
- R8: flush=1 empties the queue, drives rts_n to 0 on the next cycle, and takes priority over a write or pop in the same cycle.
- R9: rd_valid is 1 exactly when the level is non-zero. A pop on an empty queue is ignored.
- R10: With HAS_RTS=0, rts_n is held at 0 at all times, and data behaviour is identical to the HAS_RTS=1 build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Reinitialise: empty the queue and assert RTS |
| wr_valid | input | 1 | A received byte is offered this cycle |
| wr_data | input | 8 | Received byte |
| rd_pop | input | 1 | Host removes the oldest byte |
| rd_valid | output | 1 | At least one byte is stored |
| rd_data | output | 8 | Oldest stored byte |
| rts_n | output | 1 | Active-low request to send |

## Verification
The bench builds two copies that share one stimulus: one with the default depth of 32 and HAS_RTS=1, and one with HAS_RTS=0. The first copy places the watermarks at 16 and 8. With that depth, filling the queue, overflowing it, and wrapping the pointers take only a few dozen cycles. The second copy allows every cycle to compare its pinned-low flow-control output and its data path against the first copy.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // What happens to the fill level at the next clock edge
  typedef enum logic [1:0] {
    LV_HOLD  = 2'd0,
    LV_UP    = 2'd1,
    LV_DOWN  = 2'd2,
    LV_CLEAR = 2'd3
  } lv_op_t;
endpackage

// File: rtl/rxq_wrap_ptr.sv
module rxq_wrap_ptr #(
  parameter int DEPTH = 32,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      // Natural binary rollover wraps the pointer
      always_ff @(posedge clk) begin
        if (rst || clr)  ptr <= '0;
        else if (step)   ptr <= ptr + 1'b1;
      end
    end else begin : g_cmp
      // Explicit compare when the depth is not a power of two
      always_ff @(posedge clk) begin
        if (rst || clr)  ptr <= '0;
        else if (step)   ptr <= (ptr == LAST_IDX) ? '0 : ptr + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/rxq_level.sv
module rxq_level
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  lv_op_t           op,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             empty
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      unique case (op)
        LV_UP:    cnt <= cnt + 1'b1;
        LV_DOWN:  cnt <= cnt - 1'b1;
        LV_CLEAR: cnt <= '0;
        default:  cnt <= cnt;
      endcase
    end
  end

  assign full  = (cnt == FULL_LVL);
  assign empty = (cnt == '0);
endmodule

// File: rtl/rxq_rts_ctl.sv
module rxq_rts_ctl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  lv_op_t           op,
  input  logic [CNT_W-1:0] cnt,
  output logic             rts_n
);
  // Levels before the update that cross a watermark
  localparam logic [CNT_W-1:0] STOP_FROM   = CNT_W'(DEPTH / 2 - 1);
  localparam logic [CNT_W-1:0] RESUME_FROM = CNT_W'(DEPTH / 4 + 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_n <= 1'b0;
    end else begin
      unique case (op)
        LV_CLEAR: rts_n <= 1'b0;
        LV_UP:    if (cnt == STOP_FROM)   rts_n <= 1'b1;
        LV_DOWN:  if (cnt == RESUME_FROM) rts_n <= 1'b0;
        default:  rts_n <= rts_n;
      endcase
    end
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  // No reset on the array so it maps to distributed RAM
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_flowctl.sv
module rxq_flowctl
  import rxq_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int DATA_W  = 8,
  parameter int HAS_RTS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_pop,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rts_n
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] fill_cnt;
  logic             q_full, q_empty;
  logic             push_ok, pop_ok;
  logic [PTR_W-1:0] head_ptr, tail_ptr;
  lv_op_t           lv_op;

  assign push_ok = wr_valid & ~q_full & ~flush;
  assign pop_ok  = rd_pop & ~q_empty & ~flush;

  always_comb begin
    if (flush)                  lv_op = LV_CLEAR;
    else if (push_ok & ~pop_ok) lv_op = LV_UP;
    else if (pop_ok & ~push_ok) lv_op = LV_DOWN;
    else                        lv_op = LV_HOLD;
  end

  rxq_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
    .clk(clk), .rst(rst), .op(lv_op),
    .cnt(fill_cnt), .full(q_full), .empty(q_empty)
  );

  rxq_wrap_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_head (
    .clk(clk), .rst(rst), .clr(flush), .step(push_ok), .ptr(head_ptr)
  );

  rxq_wrap_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_tail (
    .clk(clk), .rst(rst), .clr(flush), .step(pop_ok), .ptr(tail_ptr)
  );

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
    .clk(clk), .we(push_ok), .waddr(head_ptr), .wdata(wr_data),
    .raddr(tail_ptr), .rdata(rd_data)
  );

  generate
    if (HAS_RTS != 0) begin : g_rts
      rxq_rts_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rts (
        .clk(clk), .rst(rst), .op(lv_op), .cnt(fill_cnt), .rts_n(rts_n)
      );
    end else begin : g_no_rts
      assign rts_n = 1'b0;
    end
  endgenerate

  assign rd_valid = ~q_empty;
endmodule

// File: rtl/rxq_flowctl_chk.sv
module rxq_flowctl_chk #(
  parameter int DEPTH   = 32,
  parameter int CNT_W   = $clog2(DEPTH + 1),
  parameter int HAS_RTS = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             wr_valid,
  input logic             rd_pop,
  input logic             rd_valid,
  input logic             rts_n,
  input logic [CNT_W-1:0] level
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HI_M1    = CNT_W'(DEPTH / 2 - 1);
  localparam logic [CNT_W-1:0] LO_P1    = CNT_W'(DEPTH / 4 + 1);

  logic acc_w, acc_r;
  assign acc_w = wr_valid && (level != FULL_LVL) && !flush;
  assign acc_r = rd_pop && (level != '0) && !flush;

  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> (!rd_valid && !rts_n));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_LVL);

  p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (level == FULL_LVL && wr_valid && !rd_pop && !flush) |=> level == FULL_LVL);

  generate
    if (HAS_RTS != 0) begin : g_rts_props
      p_stop_mark_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_w && !acc_r && level == HI_M1) |=> rts_n);

      p_resume_mark_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_r && !acc_w && level == LO_P1) |=> !rts_n);
    end
  endgenerate

  p_pair_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_w && acc_r) |=> ($stable(level) && $stable(rts_n)));

  p_flush_clear_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!rd_valid && !rts_n));

  p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
    (!rd_valid && !wr_valid && !flush) |=> !rd_valid);
endmodule

bind rxq_flowctl rxq_flowctl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .HAS_RTS(HAS_RTS)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .wr_valid(wr_valid), .rd_pop(rd_pop),
  .rd_valid(rd_valid), .rts_n(rts_n), .level(fill_cnt)
);

// File: tb/rxq_flowctl_bench.sv
`timescale 1ns/1ps
module rxq_flowctl_bench;
  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flush = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_pop = 1'b0;
  logic       rd_valid, rd_valid_nr;
  logic [7:0] rd_data, rd_data_nr;
  logic       rts_n, rts_n_nr;

  always #4 clk = ~clk;

  rxq_flowctl #(.DEPTH(DEPTH), .DATA_W(8), .HAS_RTS(1)) u_rxq_flowctl (
    .clk(clk), .rst(rst), .flush(flush), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_pop(rd_pop), .rd_valid(rd_valid), .rd_data(rd_data), .rts_n(rts_n)
  );

  rxq_flowctl #(.DEPTH(DEPTH), .DATA_W(8), .HAS_RTS(0)) u_rxq_flowctl_nr (
    .clk(clk), .rst(rst), .flush(flush), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_pop(rd_pop), .rd_valid(rd_valid_nr), .rd_data(rd_data_nr), .rts_n(rts_n_nr)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Reference queue built from the requirements
  logic [7:0] m_q [DEPTH];
  int m_head = 0, m_tail = 0, m_cnt = 0;
  bit m_rts = 0;

  // Vector bits: {flush, push, pop, data[7:0]}
  localparam int VLEN = 16;
  localparam logic [10:0] VEC [VLEN] = '{
    {3'b010, 8'h11}, {3'b010, 8'h22}, {3'b010, 8'h33}, {3'b001, 8'h00},
    {3'b011, 8'h44}, {3'b011, 8'h55}, {3'b001, 8'h00}, {3'b001, 8'h00},
    {3'b001, 8'h00}, {3'b001, 8'h00}, {3'b011, 8'h66}, {3'b010, 8'h77},
    {3'b010, 8'h88}, {3'b001, 8'h00}, {3'b011, 8'h99}, {3'b001, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(rd_valid == (m_cnt != 0), req, "rd_valid", int'(rd_valid), int'(m_cnt != 0));
    if (m_cnt != 0)
      chk(rd_data == m_q[m_tail], req, "rd_data", int'(rd_data), int'(m_q[m_tail]));
    chk(rts_n == m_rts, req, "rts_n", int'(rts_n), int'(m_rts));
    // R10: the variant without flow control keeps the line low and the same data
    chk(rts_n_nr == 1'b0, "R10", "rts_n_nr", int'(rts_n_nr), 0);
    chk(rd_valid_nr == rd_valid, "R10", "rd_valid_nr", int'(rd_valid_nr), int'(rd_valid));
    if (m_cnt != 0)
      chk(rd_data_nr == m_q[m_tail], "R10", "rd_data_nr", int'(rd_data_nr), int'(m_q[m_tail]));
  endtask

  task automatic step(input bit push, input logic [7:0] d, input bit pop, input bit fl);
    bit pw, pr;
    @(negedge clk);
    wr_valid = push; wr_data = d; rd_pop = pop; flush = fl;
    @(posedge clk);
    pw = push && (m_cnt != DEPTH);
    pr = pop && (m_cnt != 0);
    if (fl) begin
      m_cnt = 0; m_head = 0; m_tail = 0; m_rts = 0;
    end else begin
      if (pw && !pr && m_cnt == DEPTH / 2 - 1) m_rts = 1;
      if (pr && !pw && m_cnt == DEPTH / 4 + 1) m_rts = 0;
      if (pw) begin m_q[m_head] = d; m_head = (m_head + 1) % DEPTH; m_cnt++; end
      if (pr) begin m_tail = (m_tail + 1) % DEPTH; m_cnt--; end
    end
    #2;
  endtask

  task automatic idle_inputs();
    @(negedge clk);
    wr_valid = 0; rd_pop = 0; flush = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    check_all("R1");

    // R9: pop on an empty queue is ignored
    step(0, 8'h00, 1, 0);
    check_all("R9");

    // R2, R6, R9: table of mixed traffic
    for (int i = 0; i < VLEN; i++) begin
      step(VEC[i][9], VEC[i][7:0], VEC[i][8], VEC[i][10]);
      check_all("R2");
    end

    // R8: flush with a write in the same cycle
    step(1, 8'hA1, 0, 0);
    step(1, 8'hA2, 0, 0);
    step(1, 8'hAA, 1, 1);
    check_all("R8");

    // R4: climb to the stop mark
    for (int i = 0; i < 16; i++) begin
      step(1, 8'(i * 7 + 3), 0, 0);
      check_all(i == 15 ? "R4" : "R6");
    end
    chk(rts_n == 1'b1, "R4", "rts_n at 16", int'(rts_n), 1);

    // R6: hysteresis on the way down and paired traffic
    for (int i = 0; i < 7; i++) begin
      step(0, 8'h00, 1, 0);
      check_all("R6");
    end
    step(1, 8'h5C, 1, 0);
    check_all("R6");
    chk(rts_n == 1'b1, "R6", "rts_n held at 9", int'(rts_n), 1);

    // R5: reach the resume mark
    step(0, 8'h00, 1, 0);
    check_all("R5");
    chk(rts_n == 1'b0, "R5", "rts_n at 8", int'(rts_n), 0);

    // R6: paired traffic at 15 does not cross the stop mark
    for (int i = 0; i < 7; i++) step(1, 8'(8'hC0 + i), 0, 0);
    step(1, 8'hCF, 1, 0);
    check_all("R6");
    chk(rts_n == 1'b0, "R6", "rts_n paired at 15", int'(rts_n), 0);

    // R3: fill, then overflow attempts
    while (m_cnt < DEPTH) step(1, 8'(m_cnt * 5 + 1), 0, 0);
    check_all("R3");
    step(1, 8'hEE, 0, 0);
    check_all("R3");
    step(1, 8'hEF, 1, 0);
    check_all("R3");

    // R7: drain and refill several times across the wrap point
    for (int i = 0; i < 80; i++) begin
      step((i % 3) != 2, 8'(i + 8'h40), 1, 0);
      check_all("R7");
    end
    while (m_cnt > 0) begin
      step(0, 8'h00, 1, 0);
      check_all("R7");
    end
    chk(rd_valid == 1'b0, "R9", "rd_valid after drain", int'(rd_valid), 0);

    // R8: flush from a high level with flow stopped
    for (int i = 0; i < 20; i++) step(1, 8'(i), 0, 0);
    check_all("R4");
    step(0, 8'h00, 1, 1);
    check_all("R8");
    step(1, 8'h3D, 0, 0);
    check_all("R8");

    // R1: reset in the middle of traffic
    @(negedge clk); rst = 1; wr_valid = 1; wr_data = 8'h77;
    @(posedge clk); #2;
    m_cnt = 0; m_head = 0; m_tail = 0; m_rts = 0;
    @(negedge clk); rst = 0; wr_valid = 0;
    #1;
    check_all("R1");

    idle_inputs();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule